// File: doc/BRIEF.md
# LPC Bus Target Cycle Engine

This block is the target side of a Low Pin Count bus for a small memory-mapped device. It samples an active-low cycle frame strobe and a 4-bit multiplexed nibble bus on every rising clock edge. From the nibble stream it recognises the start field, the combined cycle-type and direction field, and an eight-nibble memory address. It then either returns one byte to the host or takes one byte from it, inserting wait states through sync codes for as long as the device behind it needs.

Toward the device the engine presents a plain port: an address, write data, a one-clock write strobe, a one-clock read strobe, read data and a ready level. The nibble bus is split into an input, an output and an output enable so that the pad ring can build the tri-state buffer. The engine releases the bus when the host drops the frame strobe mid-cycle, while no cycle is active, and while either of its two reset inputs is low.

Top module: `lpc_target_engine`

## Requirements
- R1: A cycle begins only when `cyc_n` is 0 at a rising edge and `bus_in` is 4'b0000; any other value leaves the engine idle, with no bus drive and no device strobe.
- R2: The nibble after the start selects the operation: 4'b0100 is a memory read, 4'b0110 is a memory write, and any other code is ignored until the next start.
- R3: The address is taken as 8 nibbles, most significant first, and forms the 32-bit `dev_addr`; the engine answers only when `dev_addr[31:24]` equals `base_addr`, and otherwise stays silent.
- R4: On a read, the host owns the two clocks after the address, `dev_re` is high for exactly the first of them, and then the engine drives 4'b0101 for one or more clocks until `dev_ready` is seen, then 4'b0000, then `dev_rdata[3:0]`, then `dev_rdata[7:4]`.
- R5: On a write, the two nibbles after the address are the data, bits 3:0 first; `dev_we` is high for the one clock after the high nibble with `dev_addr` and `dev_wdata` valid; after two host turnaround clocks the engine drives 4'b0101 until `dev_ready`, then 4'b0000.
- R6: After its last field the engine drives 4'b1111 for one clock and then releases the bus.
- R7: When `cyc_n` is 0 at a rising edge during any field after the start, the cycle is dropped, `bus_oe` is 0 for as long as `cyc_n` is 0, and no further strobe follows for that cycle.
- R8: A write whose high data nibble was taken is committed (its `dev_we` strobe occurs) even when the frame strobe drops in the first host turnaround clock; a drop before that commits nothing.
- R9: With `cyc_n` high and no cycle in progress, `bus_oe` stays 0.
- R10: While `if_rst_n` or `cpu_rst_n` is 0, `bus_oe`, `dev_we` and `dev_re` are 0 at once and any cycle is discarded; after release the engine waits for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| if_rst_n | input | 1 | Interface reset, active low, asynchronous |
| cpu_rst_n | input | 1 | Processor reset, active low, asynchronous |
| cyc_n | input | 1 | Cycle frame strobe from the host, active low |
| bus_in | input | 4 | Nibble bus as seen at the pad |
| bus_out | output | 4 | Nibble the engine drives |
| bus_oe | output | 1 | Output enable for the nibble bus pads |
| base_addr | input | 8 | Address window selecting this target |
| dev_addr | output | 32 | Device address |
| dev_wdata | output | 8 | Device write data |
| dev_we | output | 1 | Device write strobe, one clock |
| dev_re | output | 1 | Device read strobe, one clock |
| dev_rdata | input | 8 | Device read data, valid with dev_ready |
| dev_ready | input | 1 | Device completion level, sampled during wait states |

## Verification
The bench drops the frame strobe at every clock position of a read and of a write, because a design that only checked for abort in some states would keep driving sync or data onto a bus the host has reclaimed, and one that strobed the write late would lose data dropped in the turnaround window or commit data the host cut short. Wait counts of zero up to several clocks are used, since an off-by-one in sync handling shows as a missing 4'b0101 clock or a byte returned before the device had it. Read data whose nibbles differ, and one that is all ones, expose a swapped nibble order and a turnaround that is confused with data. Both reset inputs are pulsed mid-cycle, including after a write strobe, and non-matching addresses, bad start codes and bad cycle types are sent to show that a design which responds loosely would drive the bus or strobe the device.

// File: rtl/lpc_target_engine.sv
module lpc_target_engine #(
  parameter int ADDR_NIB = 8,
  parameter int BASE_W   = 8
) (
  input  logic                  clk,
  input  logic                  if_rst_n,
  input  logic                  cpu_rst_n,
  input  logic                  cyc_n,
  input  logic [3:0]            bus_in,
  output logic [3:0]            bus_out,
  output logic                  bus_oe,
  input  logic [BASE_W-1:0]     base_addr,
  output logic [4*ADDR_NIB-1:0] dev_addr,
  output logic [7:0]            dev_wdata,
  output logic                  dev_we,
  output logic                  dev_re,
  input  logic [7:0]            dev_rdata,
  input  logic                  dev_ready
);
  localparam int AW = 4 * ADDR_NIB;
  localparam int CW = $clog2(ADDR_NIB);
  localparam logic [3:0] C_START = 4'b0000;
  localparam logic [3:0] C_MRD   = 4'b0100;
  localparam logic [3:0] C_MWR   = 4'b0110;
  localparam logic [3:0] C_WAIT  = 4'b0101;
  localparam logic [3:0] C_OK    = 4'b0000;
  localparam logic [3:0] C_TAR   = 4'b1111;

  typedef enum logic [3:0] {
    S_IDLE, S_CTYPE, S_ADDR, S_WD0, S_WD1, S_HT1, S_HT2,
    S_SYNC, S_SOK, S_RD0, S_RD1, S_TT1, S_TT2
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;
  logic          is_wr;

  wire in_rst  = !if_rst_n || !cpu_rst_n;
  wire busy    = (st != S_IDLE) && (st != S_CTYPE);
  wire abort   = busy && !cyc_n;
  wire [AW-1:0] addr_nx = {addr[AW-5:0], bus_in};
  wire hit     = addr_nx[AW-1 -: BASE_W] == base_addr;
  wire drive   = (st == S_SYNC) || (st == S_SOK) || (st == S_RD0) ||
                 (st == S_RD1) || (st == S_TT1);

  always_ff @(posedge clk or negedge if_rst_n or negedge cpu_rst_n) begin
    if (!if_rst_n || !cpu_rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      addr  <= '0;
      wdata <= '0;
      rdata <= '0;
      is_wr <= 1'b0;
    end else if (abort) begin
      st <= S_IDLE;
    end else begin
      unique case (st)
        S_IDLE:  if (!cyc_n && bus_in == C_START) st <= S_CTYPE;
        S_CTYPE: begin
          if (!cyc_n) st <= (bus_in == C_START) ? S_CTYPE : S_IDLE;
          else if (bus_in == C_MRD || bus_in == C_MWR) begin
            is_wr <= (bus_in == C_MWR);
            cnt   <= '0;
            st    <= S_ADDR;
          end else st <= S_IDLE;
        end
        S_ADDR: begin
          addr <= addr_nx;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(ADDR_NIB - 1))
            st <= !hit ? S_IDLE : (is_wr ? S_WD0 : S_HT1);
        end
        S_WD0: begin
          wdata[3:0] <= bus_in;
          st <= S_WD1;
        end
        S_WD1: begin
          wdata[7:4] <= bus_in;
          st <= S_HT1;
        end
        S_HT1: st <= S_HT2;
        S_HT2: st <= S_SYNC;
        S_SYNC: if (dev_ready) begin
          if (!is_wr) rdata <= dev_rdata;
          st <= S_SOK;
        end
        S_SOK: st <= is_wr ? S_TT1 : S_RD0;
        S_RD0: st <= S_RD1;
        S_RD1: st <= S_TT1;
        S_TT1: st <= S_TT2;
        S_TT2: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      S_SYNC:  bus_out = C_WAIT;
      S_SOK:   bus_out = C_OK;
      S_RD0:   bus_out = rdata[3:0];
      S_RD1:   bus_out = rdata[7:4];
      S_TT1:   bus_out = C_TAR;
      default: bus_out = 4'b0000;
    endcase
  end

  assign bus_oe    = drive && cyc_n;
  assign dev_we    = (st == S_HT1) && is_wr;
  assign dev_re    = (st == S_HT1) && !is_wr;
  assign dev_addr  = addr;
  assign dev_wdata = wdata;

  assert_abort_release_R7: assert property (@(posedge clk) disable iff (in_rst)
    !cyc_n |=> !bus_oe);

  assert_we_single_R5: assert property (@(posedge clk) disable iff (in_rst)
    dev_we |=> !dev_we);

  assert_host_tar_R4: assert property (@(posedge clk) disable iff (in_rst)
    (dev_re || dev_we) |=> !bus_oe);

  assert_tar_release_R6: assert property (@(posedge clk) disable iff (in_rst)
    ($fell(bus_oe) && cyc_n) |-> $past(bus_out) == C_TAR);

  assert_sync_first_R4: assert property (@(posedge clk) disable iff (in_rst)
    ($rose(bus_oe) && cyc_n) |-> bus_out == C_WAIT);
endmodule

// File: tb/lpc_target_engine_tb.sv
module lpc_target_engine_tb;
  localparam logic [7:0] BASE = 8'h3C;

  logic        clk = 1'b0;
  logic        if_rst_n = 1'b0, cpu_rst_n = 1'b1, cyc_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe, dev_we, dev_re, dev_ready;
  logic [31:0] dev_addr;
  logic [7:0]  dev_wdata, dev_rdata;

  int nchk = 0, nbad = 0;
  bit done = 0;

  int dly = 0, wcnt = 0, wr_count = 0;
  logic [7:0]  last_wd = '0;
  logic [31:0] last_wa = '0;
  logic [31:0] exp_a;
  logic [7:0]  exp_d;

  int q_f[$], q_l[$], q_oe[$], q_out[$], q_we[$], q_re[$];
  string q_tag[$];

  always #10 clk = ~clk;

  lpc_target_engine u_dut (
    .clk(clk), .if_rst_n(if_rst_n), .cpu_rst_n(cpu_rst_n), .cyc_n(cyc_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .base_addr(BASE),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_we(dev_we), .dev_re(dev_re),
    .dev_rdata(dev_rdata), .dev_ready(dev_ready)
  );

  function automatic logic [7:0] rdf(logic [31:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  assign dev_rdata = rdf(dev_addr);
  assign dev_ready = (wcnt == 0);

  always @(posedge clk) begin
    if (dev_we || dev_re) wcnt <= dly;
    else if (wcnt > 0) wcnt <= wcnt - 1;
    if (dev_we) begin
      wr_count <= wr_count + 1;
      last_wd  <= dev_wdata;
      last_wa  <= dev_addr;
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clearq();
    q_f.delete(); q_l.delete(); q_oe.delete(); q_out.delete();
    q_we.delete(); q_re.delete(); q_tag.delete();
  endtask

  task automatic push(int f, int l, int oe, int o, int we, int re, string t);
    q_f.push_back(f); q_l.push_back(l); q_oe.push_back(oe); q_out.push_back(o);
    q_we.push_back(we); q_re.push_back(re); q_tag.push_back(t);
  endtask

  task automatic build(bit wr, logic [31:0] a, logic [7:0] d, int dl);
    string t = wr ? "R5" : "R4";
    int ns = (dl < 1) ? 1 : dl;
    logic [7:0] rd = rdf(a);
    clearq();
    push(0, 0, 0, 0, 0, 0, "R1");
    push(1, wr ? 6 : 4, 0, 0, 0, 0, "R2");
    for (int n = 7; n >= 0; n--) push(1, int'(a[n*4 +: 4]), 0, 0, 0, 0, "R3");
    if (a[31:24] != BASE) begin
      repeat (4) push(1, 15, 0, 0, 0, 0, "R3");
      return;
    end
    if (wr) begin
      push(1, int'(d[3:0]), 0, 0, 0, 0, "R5");
      push(1, int'(d[7:4]), 0, 0, 0, 0, "R5");
      push(1, 15, 0, 0, 1, 0, "R5");
    end else push(1, 15, 0, 0, 0, 1, "R4");
    push(1, 15, 0, 0, 0, 0, t);
    repeat (ns) push(1, 15, 1, 5, 0, 0, t);
    push(1, 15, 1, 0, 0, 0, t);
    if (!wr) begin
      push(1, 15, 1, int'(rd[3:0]), 0, 0, "R4");
      push(1, 15, 1, int'(rd[7:4]), 0, 0, "R4");
    end
    push(1, 15, 1, 15, 0, 0, "R6");
    push(1, 15, 0, 0, 0, 0, "R6");
    push(1, 15, 0, 0, 0, 0, "R9");
  endtask

  task automatic execute(int mode, int k);
    for (int i = 0; i < q_f.size(); i++) begin
      bit cut = (mode != 0) && (i == k);
      int f = q_f[i], l = q_l[i], eoe = q_oe[i], ewe = q_we[i], ere = q_re[i];
      string tg = q_tag[i];
      if (cut) begin
        l = 15; eoe = 0;
        if (mode == 1) begin f = 0; tg = "R7"; end
        else begin ewe = 0; ere = 0; tg = "R10"; end
      end
      @(negedge clk);
      cyc_n = f[0]; bus_in = l[3:0];
      if_rst_n  = !(cut && mode == 2);
      cpu_rst_n = !(cut && mode == 3);
      #5;
      check(tg, "oe", bus_oe, eoe);
      if (eoe != 0) check(tg, "out", bus_out, q_out[i]);
      check(tg, "we", dev_we, ewe);
      check(tg, "re", dev_re, ere);
      if (ewe != 0 || ere != 0) check("R3", "addr", dev_addr, exp_a);
      if (ewe != 0) check("R5", "wdata", dev_wdata, exp_d);
      if (cut) begin
        @(negedge clk);
        cyc_n = 1'b1; bus_in = 4'hF; if_rst_n = 1'b1; cpu_rst_n = 1'b1;
        #5;
        check(tg, "oe_after", bus_oe, 0);
        check(tg, "we_after", dev_we, 0);
        check(tg, "re_after", dev_re, 0);
        break;
      end
    end
  endtask

  task automatic do_cycle(bit wr, logic [31:0] a, logic [7:0] d, int dl, int mode, int k);
    int wc0;
    bit commit = wr && (a[31:24] == BASE) &&
                 (mode == 0 || (mode == 1 && k >= 12) || (mode >= 2 && k >= 13));
    dly = dl; exp_a = a; exp_d = d;
    build(wr, a, d, dl);
    wc0 = wr_count;
    execute(mode, k);
    @(negedge clk);
    check("R8", "commits", wr_count - wc0, commit);
    if (commit) begin
      check("R5", "stored_data", last_wd, d);
      check("R5", "stored_addr", last_wa, a);
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk); #5;
      check("R10", "reset_oe", bus_oe, 0);
      check("R10", "reset_we", dev_we, 0);
      check("R10", "reset_re", dev_re, 0);
    end
    @(negedge clk); if_rst_n = 1'b1;
    repeat (2) begin @(negedge clk); #5; check("R9", "standby_oe", bus_oe, 0); end

    do_cycle(0, 32'h3C00_1234, 8'h00, 0, 0, 0);
    do_cycle(0, 32'h3CA5_F00F, 8'h00, 3, 0, 0);
    do_cycle(0, 32'h3C12_3456, 8'h00, 1, 0, 0);
    do_cycle(1, 32'h3C00_0040, 8'hC3, 0, 0, 0);
    do_cycle(1, 32'h3CFF_FF10, 8'h5A, 2, 0, 0);
    do_cycle(0, 32'h3D00_1234, 8'h00, 0, 0, 0);
    do_cycle(1, 32'h1C00_0040, 8'h77, 0, 0, 0);

    clearq();
    push(0, 3, 0, 0, 0, 0, "R1");
    push(1, 4, 0, 0, 0, 0, "R1");
    for (int n = 0; n < 8; n++) push(1, (n == 0) ? 3 : 12, 0, 0, 0, 0, "R1");
    repeat (6) push(1, 15, 0, 0, 0, 0, "R1");
    execute(0, 0);

    clearq();
    push(0, 0, 0, 0, 0, 0, "R2");
    push(1, 2, 0, 0, 0, 0, "R2");
    for (int n = 0; n < 8; n++) push(1, (n == 0) ? 3 : 12, 0, 0, 0, 0, "R2");
    repeat (6) push(1, 15, 0, 0, 0, 0, "R2");
    execute(0, 0);

    for (int k = 1; k < 20; k++) do_cycle(0, 32'h3C00_2B3C, 8'h00, 2, 1, k);
    for (int k = 1; k < 19; k++) do_cycle(1, 32'h3C01_0203, 8'h96, 1, 1, k);

    do_cycle(0, 32'h3C00_0707, 8'h00, 2, 2, 13);
    do_cycle(1, 32'h3C00_0808, 8'hE1, 2, 3, 13);
    do_cycle(1, 32'h3C00_0909, 8'h1E, 2, 3, 11);
    do_cycle(1, 32'h3C00_0A0A, 8'h3D, 2, 2, 5);
    do_cycle(0, 32'h3C00_0B0C, 8'h00, 1, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule